// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block takes one routing request from an interrupt redirection entry and delivers its vector to processors. The request carries a destination ID, a destination mode flag, a delivery mode code, a vector, a trigger-mode flag and the number of the source pin. From a table of per-processor physical IDs, logical IDs and present flags, the block first builds a target mask. It then sends per-processor inject strobes, either to every target or to the single target with the lowest priority value. When the request completes, it gives a one-cycle completion pulse and a flag that says whether anything was injected.

The controller is a four-state machine. `ST_IDLE` waits for a request. An accept (`req_valid` while `busy` is low) latches the request and moves to `ST_RESOLVE`. In `ST_RESOLVE` the target set is computed and registered. Transition *resolve-to-send* is taken when the set is non-empty. Transition *resolve-to-done* is taken when the set is empty. `ST_SEND` strobes one processor per cycle, lowest index first. Transition *send-to-done* is taken with the last target. `ST_DONE` pulses `done` for one cycle and then takes *done-to-idle*. The per-processor table and priorities must stay stable from accept until `done`.

Top module: `irq_route_dispatch`

## Requirements
- R1: Physical mode (`req_logical`=0) with destination all-ones (0xFF) targets every processor whose present flag is set, and no others.
- R2: Physical mode with any other destination targets only the lowest-indexed present processor whose physical ID equals the destination.
- R3: Logical mode with destination 0 targets nothing. With any other destination it targets every present processor whose logical ID shares at least one set bit with the destination.
- R4: When the target mask is empty, no strobe is issued and `delivered` is 0 in the `done` cycle.
- R5: Delivery code 3'b000 (fixed) strobes each target once, one target per cycle, in ascending index order. At most one strobe bit is high in any cycle.
- R6: Delivery code 3'b001 (lowest priority) strobes exactly one processor from the mask: the one with the smallest priority value, with ties going to the lowest index.
- R7: For source pin 0, when the mask is non-empty, fixed mode targets only processor 0 and lowest-priority mode targets processor 0. Either is delivered only if processor 0 is present.
- R8: Any delivery code other than 3'b000 and 3'b001 produces no strobe and `delivered` 0.
- R9: Every strobe carries the vector and trigger flag latched at accept. `done` is high for exactly one cycle, the cycle after the last strobe (or after resolve when there is no target). `delivered` is 1 there exactly when at least one strobe was issued.
- R10: `busy` is high from the cycle after accept until `done`. A `req_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_dest | input | ID_W | Destination ID |
| req_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| req_dmode | input | 3 | Delivery mode code (000 fixed, 001 lowest priority) |
| req_vector | input | VEC_W | Vector to inject |
| req_level | input | 1 | Trigger mode passed with the vector (1 = level) |
| req_pin | input | PIN_W | Source pin number |
| cpu_present | input | N_CPU | Per-processor present flag |
| cpu_phys_id | input | N_CPU*ID_W | Physical IDs, processor i at bits [i*ID_W +: ID_W] |
| cpu_log_id | input | N_CPU*ID_W | Logical IDs, same packing |
| cpu_prio | input | N_CPU*PRIO_W | Priority values, lower wins, same packing |
| busy | output | 1 | Request in progress |
| inj_strobe | output | N_CPU | Per-processor inject strobe |
| inj_vector | output | VEC_W | Vector carried with the strobe |
| inj_level | output | 1 | Trigger mode carried with the strobe |
| done | output | 1 | One-cycle completion pulse |
| delivered | output | 1 | Valid with done: at least one strobe issued |

## Verification
The bound checker watches several properties on every cycle. Strobes are one-hot-or-zero, go only to present processors, occur only while busy, and rise in index within a burst. `done` is a single-cycle pulse that follows the last strobe with `delivered` set. The bench's scenarios are the only way to show which processors are selected. These cover broadcast against single physical match, the logical zero destination, logical multi-match with an absent processor, priority ties, the pin 0 overrides, unsupported delivery codes, and a request dropped while busy. A scoreboard compares every strobe and completion against a model of these rules.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_SEND    = 2'd2,
        ST_DONE    = 2'd3
    } route_state_e;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWEST = 3'b001;
endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] onehot
);
    always_comb begin
        logic found;
        found  = 1'b0;
        onehot = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_in[i] && !found) begin
                onehot[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
    parameter int N_CPU = 4,
    parameter int ID_W  = 8
) (
    input  logic [ID_W-1:0]       dest,
    input  logic                  logical,
    input  logic [N_CPU-1:0]      present,
    input  logic [N_CPU*ID_W-1:0] phys_ids,
    input  logic [N_CPU*ID_W-1:0] log_ids,
    output logic [N_CPU-1:0]      mask
);
    localparam logic [ID_W-1:0] ALL_ID = {ID_W{1'b1}};

    logic [N_CPU-1:0] phys_hit;
    logic [N_CPU-1:0] phys_first;
    logic [N_CPU-1:0] log_hit;

    for (genvar g = 0; g < N_CPU; g++) begin : g_cmp
        assign phys_hit[g] = present[g] && (phys_ids[g*ID_W +: ID_W] == dest);
        assign log_hit[g]  = present[g] && ((log_ids[g*ID_W +: ID_W] & dest) != '0);
    end

    irq_lsb_pick #(.W(N_CPU)) u_first (
        .vec_in (phys_hit),
        .onehot (phys_first)
    );

    always_comb begin
        if (logical) begin
            mask = (dest == '0) ? '0 : log_hit;
        end else if (dest == ALL_ID) begin
            mask = present;
        end else begin
            mask = phys_first;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_CPU  = 4,
    parameter int PRIO_W = 4
) (
    input  logic [N_CPU-1:0]        cand,
    input  logic [N_CPU*PRIO_W-1:0] prio,
    output logic [N_CPU-1:0]        winner
);
    localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    always_comb begin
        logic              have;
        logic [PRIO_W-1:0] best_p;
        logic [IDX_W-1:0]  best_i;
        have   = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (cand[i] && (!have || (prio[i*PRIO_W +: PRIO_W] < best_p))) begin
                have   = 1'b1;
                best_p = prio[i*PRIO_W +: PRIO_W];
                best_i = IDX_W'(i);
            end
        end
        winner = '0;
        if (have) winner[best_i] = 1'b1;
    end
endmodule

// File: rtl/irq_route_dispatch.sv
module irq_route_dispatch
    import irq_route_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int ID_W   = 8,
    parameter int VEC_W  = 8,
    parameter int PRIO_W = 4,
    parameter int PIN_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ID_W-1:0]         req_dest,
    input  logic                    req_logical,
    input  logic [2:0]              req_dmode,
    input  logic [VEC_W-1:0]        req_vector,
    input  logic                    req_level,
    input  logic [PIN_W-1:0]        req_pin,
    input  logic [N_CPU-1:0]        cpu_present,
    input  logic [N_CPU*ID_W-1:0]   cpu_phys_id,
    input  logic [N_CPU*ID_W-1:0]   cpu_log_id,
    input  logic [N_CPU*PRIO_W-1:0] cpu_prio,
    output logic                    busy,
    output logic [N_CPU-1:0]        inj_strobe,
    output logic [VEC_W-1:0]        inj_vector,
    output logic                    inj_level,
    output logic                    done,
    output logic                    delivered
);
    localparam logic [N_CPU-1:0] CPU0_ONLY = N_CPU'(1);

    route_state_e state_q, state_d;

    logic [ID_W-1:0]  dest_q;
    logic             logical_q;
    logic [2:0]       dmode_q;
    logic [VEC_W-1:0] vector_q;
    logic             level_q;
    logic             pin_zero_q;
    logic [N_CPU-1:0] tgt_q;
    logic             sent_q;

    logic [N_CPU-1:0] dest_mask;
    logic [N_CPU-1:0] prio_win;
    logic [N_CPU-1:0] final_set;
    logic [N_CPU-1:0] send_pick;
    logic [N_CPU-1:0] tgt_left;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    irq_dest_match #(.N_CPU(N_CPU), .ID_W(ID_W)) u_match (
        .dest     (dest_q),
        .logical  (logical_q),
        .present  (cpu_present),
        .phys_ids (cpu_phys_id),
        .log_ids  (cpu_log_id),
        .mask     (dest_mask)
    );

    irq_prio_pick #(.N_CPU(N_CPU), .PRIO_W(PRIO_W)) u_prio (
        .cand   (dest_mask),
        .prio   (cpu_prio),
        .winner (prio_win)
    );

    irq_lsb_pick #(.W(N_CPU)) u_next (
        .vec_in (tgt_q),
        .onehot (send_pick)
    );

    assign tgt_left = tgt_q & ~send_pick;

    // Target set for the resolve step, pin 0 override applied after the empty check
    always_comb begin
        final_set = '0;
        if (dest_mask != '0) begin
            unique case (dmode_q)
                DM_FIXED:  final_set = pin_zero_q ? (CPU0_ONLY & cpu_present) : dest_mask;
                DM_LOWEST: final_set = pin_zero_q ? (CPU0_ONLY & cpu_present) : prio_win;
                default:   final_set = '0;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = (final_set != '0) ? ST_SEND : ST_DONE;
            ST_SEND:    if (tgt_left == '0) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch and target bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q     <= '0;
            logical_q  <= 1'b0;
            dmode_q    <= DM_FIXED;
            vector_q   <= '0;
            level_q    <= 1'b0;
            pin_zero_q <= 1'b0;
            tgt_q      <= '0;
            sent_q     <= 1'b0;
        end else begin
            if (accept) begin
                dest_q     <= req_dest;
                logical_q  <= req_logical;
                dmode_q    <= req_dmode;
                vector_q   <= req_vector;
                level_q    <= req_level;
                pin_zero_q <= (req_pin == '0);
                sent_q     <= 1'b0;
            end
            if (state_q == ST_RESOLVE) tgt_q <= final_set;
            if (state_q == ST_SEND) begin
                tgt_q  <= tgt_left;
                sent_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        inj_strobe = (state_q == ST_SEND) ? send_pick : '0;
        inj_vector = vector_q;
        inj_level  = level_q;
        done       = (state_q == ST_DONE);
        delivered  = (state_q == ST_DONE) && sent_q;
    end
endmodule

// File: rtl/irq_route_dispatch_chk.sv
module irq_route_dispatch_chk #(
    parameter int N_CPU = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             delivered,
    input logic [N_CPU-1:0] inj_strobe,
    input logic [N_CPU-1:0] cpu_present
);
    p_onehot_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_strobe));

    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_strobe != '0 && $past(inj_strobe) != '0) |-> (inj_strobe > $past(inj_strobe)));

    p_present_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_strobe & ~cpu_present) == '0);

    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_strobe != '0) |-> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inj_strobe) != '0 && inj_strobe == '0) |-> (done && delivered));

    p_no_strobe_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (inj_strobe == '0));
endmodule

bind irq_route_dispatch irq_route_dispatch_chk #(.N_CPU(N_CPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .delivered   (delivered),
    .inj_strobe  (inj_strobe),
    .cpu_present (cpu_present)
);

// File: tb/irq_route_dispatch_tb.sv
module irq_route_dispatch_tb;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [7:0]     req_dest = '0;
    logic           req_logical = 1'b0;
    logic [2:0]     req_dmode = '0;
    logic [7:0]     req_vector = '0;
    logic           req_level = 1'b0;
    logic [4:0]     req_pin = 5'd1;
    logic [N-1:0]   cpu_present;
    logic [N*8-1:0] cpu_phys_id;
    logic [N*8-1:0] cpu_log_id;
    logic [N*4-1:0] cpu_prio;
    logic           busy, inj_level, done, delivered;
    logic [N-1:0]   inj_strobe;
    logic [7:0]     inj_vector;

    typedef struct { int idx; logic [7:0] vec; logic lvl; string tag; } exp_t;
    exp_t  exp_q[$];
    logic  exp_del_q[$];
    string exp_tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;

    always #2 clk = ~clk;

    irq_route_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_dmode(req_dmode), .req_vector(req_vector),
        .req_level(req_level), .req_pin(req_pin), .cpu_present(cpu_present),
        .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id), .cpu_prio(cpu_prio),
        .busy(busy), .inj_strobe(inj_strobe), .inj_vector(inj_vector),
        .inj_level(inj_level), .done(done), .delivered(delivered)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares strobes and completions against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (inj_strobe != '0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected strobe", int'(inj_strobe), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(inj_strobe == N'(1 << e.idx), e.tag, int'(inj_strobe), 1 << e.idx);
                    check(inj_vector == e.vec && inj_level == e.lvl, "R9 vector/trigger",
                          {inj_level, inj_vector}, {e.lvl, e.vec});
                end
            end
            if (done) begin
                if (exp_del_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    logic  ed;
                    string t;
                    ed = exp_del_q.pop_front();
                    t  = exp_tag_q.pop_front();
                    check(delivered == ed, {t, " delivered (R4/R9)"}, delivered, ed);
                    check(exp_q.size() == 0, {t, " missing strobes"}, 0, exp_q.size());
                end
            end
        end
    end

    // Reference model of the routing rules
    task automatic model(input logic [7:0] d, input logic lg, input logic [2:0] dm,
                         input logic [7:0] v, input logic lv, input logic [4:0] pin,
                         input string tag);
        logic [N-1:0] m;
        int pushed;
        int best;
        m = '0;
        pushed = 0;
        if (lg) begin
            for (int i = 0; i < N; i++)
                if (d != 0 && cpu_present[i] && (cpu_log_id[i*8 +: 8] & d) != 0) m[i] = 1'b1;
        end else if (d == 8'hFF) begin
            m = cpu_present;
        end else begin
            for (int i = 0; i < N; i++)
                if (m == 0 && cpu_present[i] && cpu_phys_id[i*8 +: 8] == d) m[i] = 1'b1;
        end
        if (m != 0) begin
            if (dm == 3'b000) begin
                if (pin == 0) m = {{(N-1){1'b0}}, cpu_present[0]};
                for (int i = 0; i < N; i++)
                    if (m[i]) begin exp_q.push_back('{i, v, lv, tag}); pushed++; end
            end else if (dm == 3'b001) begin
                best = -1;
                for (int i = 0; i < N; i++)
                    if (m[i] && (best < 0 || cpu_prio[i*4 +: 4] < cpu_prio[best*4 +: 4])) best = i;
                if (pin == 0) best = cpu_present[0] ? 0 : -1;
                if (best >= 0) begin exp_q.push_back('{best, v, lv, tag}); pushed++; end
            end
        end
        exp_del_q.push_back(pushed > 0);
        exp_tag_q.push_back(tag);
    endtask

    // Driver
    task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] dm,
                        input logic [7:0] v, input logic lv, input logic [4:0] pin,
                        input string tag, input bit poke = 0);
        model(d, lg, dm, v, lv, pin, tag);
        @(negedge clk);
        req_dest = d; req_logical = lg; req_dmode = dm;
        req_vector = v; req_level = lv; req_pin = pin; req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_dest = 8'hFF; req_logical = 1'b0; req_dmode = 3'b000;
            req_vector = 8'hEE; req_pin = 5'd3;
            check(busy == 1'b1, "R10 busy after accept", busy, 1);
            repeat (2) @(negedge clk);
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        cpu_present = 4'b1011;
        cpu_phys_id = {8'd5, 8'd2, 8'd5, 8'd0};
        cpu_log_id  = {8'h08, 8'h04, 8'h02, 8'h01};
        cpu_prio    = {4'd2, 4'd1, 4'd1, 4'd3};
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && inj_strobe == 0, "reset state", {busy, done, inj_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        send(8'hFF, 0, 3'b000, 8'h31, 0, 5'd2, "R1 broadcast");
        send(8'd5,  0, 3'b000, 8'h32, 1, 5'd2, "R2 first physical match");
        send(8'd2,  0, 3'b000, 8'h33, 0, 5'd2, "R4 physical absent");
        send(8'd9,  0, 3'b000, 8'h34, 0, 5'd2, "R4 physical no match");
        send(8'h00, 1, 3'b000, 8'h35, 0, 5'd2, "R3 logical zero");
        send(8'h06, 1, 3'b000, 8'h36, 1, 5'd2, "R3 logical multi");
        send(8'h0C, 1, 3'b000, 8'h37, 0, 5'd2, "R3 logical skip absent");
        send(8'hFF, 0, 3'b001, 8'h38, 1, 5'd2, "R6 lowest priority");
        send(8'hFF, 0, 3'b000, 8'h39, 0, 5'd0, "R7 pin0 fixed");
        send(8'hFF, 0, 3'b001, 8'h3A, 0, 5'd0, "R7 pin0 lowest");
        send(8'h00, 1, 3'b000, 8'h3B, 0, 5'd0, "R7 pin0 empty mask");
        send(8'hFF, 0, 3'b010, 8'h3C, 0, 5'd2, "R8 unsupported mode");
        send(8'hFF, 0, 3'b111, 8'h3D, 0, 5'd2, "R8 unsupported mode 7");
        send(8'h01, 1, 3'b000, 8'h3E, 1, 5'd2, "R10 request while busy", 1);

        cpu_present = 4'b1111;
        cpu_prio    = {4'd1, 4'd1, 4'd2, 4'd2};
        send(8'hFF, 0, 3'b001, 8'h41, 0, 5'd4, "R6 tie lowest index");
        send(8'hFF, 0, 3'b000, 8'h42, 1, 5'd4, "R5 fixed all four");
        cpu_present = 4'b1110;
        send(8'hFF, 0, 3'b000, 8'h43, 0, 5'd0, "R7 pin0 cpu0 absent");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && exp_del_q.size() == 0, "R9 scoreboard drained",
              exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule